// File: doc/BRIEF.md
# Tuner Control Register Slave (two-wire)

This block sits behind a two-wire serial control bus and holds the tuning set-up of a frequency synthesizer: a 15-bit divider word, a 7-bit control word and a 4-bit band-switch word. The bus lines arrive as raw levels. They are re-timed onto the system clock, and the block finds START, STOP and clock edges in those re-timed levels. It answers to one base address and to a second address that is always valid. The strapped address bits come from a pin pair, because the resistor-divider decoding that produces them lies outside this block.

In a write, the top bit of the first data byte picks what follows. Either a divider pair (upper bits, then lower bits) follows, or a control byte and then a band-switch byte. The bytes auto-increment until STOP, and each register is committed when the last bit of its own byte has been clocked. In a read, the block returns a status byte built from a power-on flag, the lock input, the automatic charge-pump flag and a 3-bit converter code. It keeps sending that byte for as long as the master acknowledges.

Top module: `tuner_ctl_slave`

## Requirements
- R1: After reset freq_word is 0, ctrl_word is 7'b1001000, band_sw is 0, sda_pull is 0 and the power-on flag is 1.
- R2: An address byte is accepted only when its upper five bits are 11000 and its bits [2:1] equal either addr_sel or 2'b01. Bit 0 is the direction (1 = read). Any other address is not acknowledged and leaves every register unchanged.
- R3: When the first data byte has MSB 0, its bits [6:0] become freq_word[14:8] and the next byte becomes freq_word[7:0]. freq_word changes only when the 8th bit of that second byte has been clocked. If STOP comes before the second byte, freq_word is unchanged.
- R4: When the first data byte has MSB 1, its bits [6:0] are loaded into ctrl_word[6:0] (bit 6 = pump current, 5..3 = test, 2..1 = ratio select, 0 = tuning off) at the end of that byte, even when it is the only data byte.
- R5: The byte after a control byte is the band byte. Its bits [3:0] go to band_sw[3:0], with bit 3 driving switch 4, and its bits [7:4] are ignored.
- R6: After a complete divider pair or control/band pair, the next byte is decoded again by its MSB. Four-byte writes therefore work in either order.
- R7: The slave pulls SDA low during the ninth clock of every accepted address byte and of every write data byte. It never pulls SDA while idle or while receiving an address.
- R8: A read returns {por, pll_locked, cp_auto_flag, 1, 1, adc_level[2:0]} MSB first. The byte is captured when the address is acknowledged, so input changes after that point do not alter it.
- R9: While the master acknowledges, the same captured byte is sent again. A master not-acknowledge ends the read, and SDA is released.
- R10: The power-on flag clears only when a read ends with a master not-acknowledge, and no event sets it again before the next reset.
- R11: A START at any point restarts address reception, and the next data byte is decoded by its MSB. A STOP returns the block to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversamples the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock level |
| sda_i | input | 1 | Bus data level |
| sda_pull | output | 1 | When 1, the pad pulls SDA low |
| addr_sel | input | 2 | Strapped address bits [2:1] |
| pll_locked | input | 1 | Loop lock status |
| cp_auto_flag | input | 1 | Automatic charge-pump switch flag |
| adc_level | input | 3 | Converter code |
| freq_word | output | 15 | Divider register |
| ctrl_word | output | 7 | Control register |
| band_sw | output | 4 | Band-switch register |

## Verification
The bench builds the block with its default parameters: base address bits 11000, common address bits 01, control reset value 1001000 and two synchronizer stages. It straps addr_sel to 10, so the strapped address, the common address and two rejected addresses can all be driven. Each bus half-period lasts eight system clocks, which leaves room for the synchronizer and edge-detect latency before each sample. Under these settings both four-byte orders, the lone control byte, a divider pair cut short by STOP, a repeated START, multi-byte reads and the clearing of the power-on flag can all be reached.

// File: rtl/tuner_ctl_slave.sv
module tuner_ctl_slave #(
  parameter logic [4:0] ADDR_FIXED  = 5'b11000,
  parameter logic [1:0] ADDR_COMMON = 2'b01,
  parameter logic [6:0] CTRL_INIT   = 7'b1001000,
  parameter int         SYNC_LEN    = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        scl_i,
  input  logic        sda_i,
  output logic        sda_pull,
  input  logic [1:0]  addr_sel,
  input  logic        pll_locked,
  input  logic        cp_auto_flag,
  input  logic [2:0]  adc_level,
  output logic [14:0] freq_word,
  output logic [6:0]  ctrl_word,
  output logic [3:0]  band_sw
);

  typedef enum logic [2:0] {S_IDLE, S_ADDR, S_AACK, S_WDAT, S_WACK, S_RDAT, S_RACK} st_t;
  typedef enum logic [1:0] {K_SEL, K_DIV2, K_BAND} kind_t;

  logic [SYNC_LEN:0] scl_q, sda_q;
  st_t         st;
  kind_t       kind;
  logic [3:0]  cnt;
  logic [7:0]  sh, tx, stat;
  logic [6:0]  n_hi;
  logic        rd, mack, por;

  wire scl_s = scl_q[SYNC_LEN-1];
  wire scl_p = scl_q[SYNC_LEN];
  wire sda_s = sda_q[SYNC_LEN-1];
  wire sda_p = sda_q[SYNC_LEN];

  wire scl_rise = scl_s & ~scl_p;
  wire scl_fall = ~scl_s & scl_p;
  wire start_ev = scl_s & scl_p & sda_p & ~sda_s;
  wire stop_ev  = scl_s & scl_p & ~sda_p & sda_s;
  wire byte_end = scl_fall && cnt == 4'd8;

  wire addr_hit = sh[7:3] == ADDR_FIXED && (sh[2:1] == addr_sel || sh[2:1] == ADDR_COMMON);
  wire [7:0] status_now = {por, pll_locked, cp_auto_flag, 2'b11, adc_level};

  assign sda_pull = st == S_AACK || st == S_WACK || (st == S_RDAT && !tx[7]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= '1;
      sda_q <= '1;
    end else begin
      scl_q <= {scl_q[SYNC_LEN-1:0], scl_i};
      sda_q <= {sda_q[SYNC_LEN-1:0], sda_i};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      kind      <= K_SEL;
      cnt       <= '0;
      sh        <= '0;
      tx        <= '1;
      stat      <= '0;
      n_hi      <= '0;
      rd        <= 1'b0;
      mack      <= 1'b0;
      por       <= 1'b1;
      freq_word <= '0;
      ctrl_word <= CTRL_INIT;
      band_sw   <= '0;
    end else if (start_ev) begin
      st  <= S_ADDR;
      cnt <= '0;
    end else if (stop_ev) begin
      st <= S_IDLE;
    end else begin
      case (st)
        S_ADDR: begin
          if (scl_rise) begin
            sh  <= {sh[6:0], sda_s};
            cnt <= cnt + 4'd1;
          end else if (byte_end) begin
            cnt <= '0;
            if (addr_hit) begin
              st <= S_AACK;
              rd <= sh[0];
              if (sh[0]) stat <= status_now;
            end else begin
              st <= S_IDLE;
            end
          end
        end
        S_AACK: if (scl_fall) begin
          cnt  <= '0;
          kind <= K_SEL;
          if (rd) begin
            st <= S_RDAT;
            tx <= stat;
          end else begin
            st <= S_WDAT;
          end
        end
        S_WDAT: begin
          if (scl_rise) begin
            sh  <= {sh[6:0], sda_s};
            cnt <= cnt + 4'd1;
          end else if (byte_end) begin
            cnt <= '0;
            st  <= S_WACK;
            case (kind)
              K_SEL: if (sh[7]) begin
                ctrl_word <= sh[6:0];
                kind      <= K_BAND;
              end else begin
                n_hi <= sh[6:0];
                kind <= K_DIV2;
              end
              K_DIV2: begin
                freq_word <= {n_hi, sh};
                kind      <= K_SEL;
              end
              default: begin
                band_sw <= sh[3:0];
                kind    <= K_SEL;
              end
            endcase
          end
        end
        S_WACK: if (scl_fall) st <= S_WDAT;
        S_RDAT: begin
          if (scl_rise) begin
            cnt <= cnt + 4'd1;
          end else if (byte_end) begin
            cnt <= '0;
            st  <= S_RACK;
          end else if (scl_fall) begin
            tx <= {tx[6:0], 1'b1};
          end
        end
        S_RACK: begin
          if (scl_rise) begin
            mack <= ~sda_s;
          end else if (scl_fall) begin
            if (mack) begin
              st <= S_RDAT;
              tx <= stat;
            end else begin
              st  <= S_IDLE;
              por <= 1'b0;
            end
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/tuner_ctl_slave_chk.sv
module tuner_ctl_slave_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [2:0]  st,
  input logic        sda_pull,
  input logic        scl_fall,
  input logic        por,
  input logic [14:0] freq_word,
  input logic [6:0]  ctrl_word,
  input logic [3:0]  band_sw
);
  localparam logic [2:0] C_IDLE = 3'd0;
  localparam logic [2:0] C_ADDR = 3'd1;
  localparam logic [2:0] C_WDAT = 3'd3;
  localparam logic [2:0] C_RACK = 3'd6;

  // R7
  quiet_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == C_IDLE || st == C_ADDR) |-> !sda_pull);

  // R3
  freq_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(freq_word) |-> ($past(st) == C_WDAT && $past(scl_fall)));

  // R4
  ctrl_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ctrl_word) |-> ($past(st) == C_WDAT && $past(scl_fall)));

  // R5
  band_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(band_sw) |-> ($past(st) == C_WDAT && $past(scl_fall)));

  // R10
  por_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(por) |-> $past(st) == C_RACK);

  // R10
  por_no_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$rose(por));
endmodule

bind tuner_ctl_slave tuner_ctl_slave_chk u_chk (
  .clk(clk), .rst_n(rst_n), .st(st), .sda_pull(sda_pull), .scl_fall(scl_fall),
  .por(por), .freq_word(freq_word), .ctrl_word(ctrl_word), .band_sw(band_sw)
);

// File: tb/tb_tuner_ctl_slave.sv
module tb_tuner_ctl_slave;
  localparam int CLK_PERIOD = 10;
  localparam int HALF = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic scl_m = 1'b1, sda_m = 1'b1;
  logic sda_line;
  logic [1:0] addr_sel = 2'b10;
  logic pll_locked = 1'b0, cp_auto_flag = 1'b1;
  logic [2:0] adc_level = 3'd0;
  logic sda_pull;
  logic [14:0] freq_word;
  logic [6:0] ctrl_word;
  logic [3:0] band_sw;

  assign sda_line = sda_m & ~sda_pull;

  tuner_ctl_slave dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line), .sda_pull(sda_pull),
    .addr_sel(addr_sel), .pll_locked(pll_locked), .cp_auto_flag(cp_auto_flag),
    .adc_level(adc_level), .freq_word(freq_word), .ctrl_word(ctrl_word), .band_sw(band_sw)
  );

  typedef struct {
    int          req;
    int          kind;
    logic [15:0] exp;
  } item_t;

  item_t       exp_q[$];
  logic [15:0] obs_q[$];
  int n_cmp = 0, n_bad = 0;
  bit done = 1'b0;
  event chk_ev;

  // kinds: 0 freq_word, 1 ctrl_word, 2 band_sw, 3 observed bus value, 4 sda_pull
  task automatic expect_reg(input int req, input int kind, input logic [15:0] v);
    item_t it;
    it.req = req; it.kind = kind; it.exp = v;
    exp_q.push_back(it);
  endtask

  task automatic expect_obs(input int req, input logic [15:0] v, input logic [15:0] got);
    obs_q.push_back(got);
    expect_reg(req, 3, v);
  endtask

  task automatic flush();
    -> chk_ev;
    @(negedge clk);
  endtask

  initial begin
    forever begin
      @(chk_ev);
      while (exp_q.size() > 0) begin
        item_t it;
        logic [15:0] got;
        it = exp_q.pop_front();
        case (it.kind)
          0: got = {1'b0, freq_word};
          1: got = {9'd0, ctrl_word};
          2: got = {12'd0, band_sw};
          3: got = obs_q.pop_front();
          default: got = {15'd0, sda_pull};
        endcase
        n_cmp++;
        if (got !== it.exp) begin
          n_bad++;
          $display("FAIL R%0d kind %0d: got %h expected %h", it.req, it.kind, got, it.exp);
        end
      end
    end
  end

  task automatic hp();
    repeat (HALF) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; hp();
    scl_m = 1'b1; hp();
    sda_m = 1'b0; hp();
    scl_m = 1'b0; hp();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; hp();
    scl_m = 1'b1; hp();
    sda_m = 1'b1; hp();
  endtask

  task automatic put_byte(input logic [7:0] b, output logic ackd);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; hp();
      scl_m = 1'b1; hp();
      scl_m = 1'b0; hp();
    end
    sda_m = 1'b1; hp();
    scl_m = 1'b1; hp();
    ackd = ~sda_line;
    scl_m = 1'b0; hp();
  endtask

  task automatic get_byte(input bit mack, output logic [7:0] b);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      hp();
      scl_m = 1'b1; hp();
      b[i] = sda_line;
      scl_m = 1'b0;
    end
    sda_m = mack ? 1'b0 : 1'b1; hp();
    scl_m = 1'b1; hp();
    scl_m = 1'b0; hp();
    sda_m = 1'b1;
  endtask

  // R7: every accepted byte is acknowledged
  task automatic wr(input logic [7:0] adr, input int n, input logic [7:0] b0, input logic [7:0] b1,
                    input logic [7:0] b2, input logic [7:0] b3, input bit adr_ok, input bit do_stop);
    logic a;
    logic [7:0] bytes [4];
    bytes[0] = b0; bytes[1] = b1; bytes[2] = b2; bytes[3] = b3;
    bus_start();
    put_byte(adr, a);
    expect_obs(2, {15'd0, adr_ok}, {15'd0, a});
    if (adr_ok) begin
      for (int k = 0; k < n; k++) begin
        put_byte(bytes[k], a);
        expect_obs(7, 16'd1, {15'd0, a});
      end
    end
    if (do_stop) bus_stop();
  endtask

  task automatic rd(input logic [7:0] adr, input int nbytes, input logic [7:0] expv,
                    input logic [2:0] adc_after);
    logic a;
    logic [7:0] b;
    bus_start();
    put_byte(adr, a);
    expect_obs(7, 16'd1, {15'd0, a});
    adc_level = adc_after;
    for (int k = 0; k < nbytes; k++) begin
      get_byte(k < nbytes - 1, b);
      expect_obs(8, {8'd0, expv}, {8'd0, b});
    end
    // R9: released after the not-acknowledge
    expect_reg(9, 4, 16'd0);
    bus_stop();
    flush();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: got no completion, expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R1: reset state
    expect_reg(1, 0, 16'h0000);
    expect_reg(1, 1, 16'h0048);
    expect_reg(1, 2, 16'h0000);
    expect_reg(1, 4, 16'h0000);
    flush();

    pll_locked = 1'b1; cp_auto_flag = 1'b0; adc_level = 3'b011;
    // R8 R9 R10: two bytes with power-on flag set
    rd(8'hC5, 2, 8'hDB, 3'b011);
    // R10: flag cleared by the finished read
    rd(8'hC5, 1, 8'h5B, 3'b011);
    // R8: converter code changed after capture is not seen
    rd(8'hC5, 1, 8'h5B, 3'b100);
    // R2: common address read sees the new code
    rd(8'hC3, 1, 8'h5C, 3'b100);

    // R3: divider pair alone
    wr(8'hC4, 2, 8'h06, 8'h40, 8'h00, 8'h00, 1'b1, 1'b1);
    expect_reg(3, 0, 16'h0640);
    expect_reg(3, 1, 16'h0048);
    flush();

    // R2 R4 R5: control pair through the common address
    wr(8'hC2, 2, 8'hCE, 8'h08, 8'h00, 8'h00, 1'b1, 1'b1);
    expect_reg(4, 1, 16'h004E);
    expect_reg(5, 2, 16'h0008);
    expect_reg(3, 0, 16'h0640);
    flush();

    // R6: four bytes, divider first
    wr(8'hC4, 4, 8'h12, 8'h34, 8'h85, 8'hF3, 1'b1, 1'b1);
    expect_reg(6, 0, 16'h1234);
    expect_reg(6, 1, 16'h0005);
    expect_reg(5, 2, 16'h0003);
    flush();

    // R6: four bytes, control first, maximum divider
    wr(8'hC4, 4, 8'hA0, 8'h0C, 8'h7F, 8'hFF, 1'b1, 1'b1);
    expect_reg(6, 1, 16'h0020);
    expect_reg(6, 2, 16'h000C);
    expect_reg(6, 0, 16'h7FFF);
    flush();

    // R4: control byte alone
    wr(8'hC4, 1, 8'hFF, 8'h00, 8'h00, 8'h00, 1'b1, 1'b1);
    expect_reg(4, 1, 16'h007F);
    expect_reg(4, 2, 16'h000C);
    flush();

    // R2: foreign addresses rejected
    wr(8'hC6, 0, 8'h00, 8'h00, 8'h00, 8'h00, 1'b0, 1'b1);
    wr(8'hCC, 0, 8'h00, 8'h00, 8'h00, 8'h00, 1'b0, 1'b1);
    expect_reg(2, 0, 16'h7FFF);
    expect_reg(2, 1, 16'h007F);
    flush();

    // R3: divider pair cut by STOP
    wr(8'hC4, 1, 8'h01, 8'h00, 8'h00, 8'h00, 1'b1, 1'b1);
    expect_reg(3, 0, 16'h7FFF);
    flush();

    // R11: repeated START after a lone first divider byte
    wr(8'hC4, 1, 8'h02, 8'h00, 8'h00, 8'h00, 1'b1, 1'b0);
    wr(8'hC4, 1, 8'h80, 8'h00, 8'h00, 8'h00, 1'b1, 1'b1);
    expect_reg(11, 1, 16'h0000);
    expect_reg(11, 0, 16'h7FFF);
    expect_reg(11, 4, 16'h0000);
    flush();

    repeat (10) @(negedge clk);
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule